// File: doc/BRIEF.md
# Status Flags and Condition Unit

This block holds the four status flags of a small 8-bit processor: carry, zero, overflow and negative. Each flag sits in its own flip-flop with its own write path, so the sequencer can change any one of them without disturbing the rest. A flag can take a new value from the arithmetic unit, be set or cleared by an explicit strobe, or be reloaded from a status byte pulled off the stack. The block has no decimal-mode flag and no interrupt-disable flag.

The current flags are always presented as one packed status byte, ready to be pushed. A 3-bit selector picks one of eight jump conditions, and a single condition-true output reports the result to the sequencer in the same cycle. A taken conditional jump then loads its absolute 8-bit target, and the whole instruction completes in four cycles.

The flag-write priority works as a fixed ladder with four levels. From highest to lowest they are: reset, pull (restore), set/clear strobe, and ALU update. If none of these applies, the flag holds its value. The condition selector decodes through a small enumeration of flag indices.

Top module: `status_cond_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears all four flags, so `status_out` reads 8'h00.
- R2: With no pull, set or clear acting on it, a flag takes its `flag_src` bit at the next edge when its `flag_we` bit is 1, and otherwise keeps its value. The bit order of `flag_src` and `flag_we` is 0=carry, 1=zero, 2=overflow, 3=negative.
- R3: `set_carry` forces carry to 1 and `clr_carry` forces it to 0. When both are high in the same cycle, carry becomes 1.
- R4: `clr_ovf` forces overflow to 0. No input sets overflow directly; overflow can become 1 only through the ALU path or a pull.
- R5: When `pull_en` is high, all four flags load from `pull_byte` at once: carry from bit 0, zero from bit 1, overflow from bit 6 and negative from bit 7. Bits 2 to 5 of `pull_byte` have no effect.
- R6: If more than one write source acts on a flag in the same cycle, a pull wins over set or clear, and set or clear wins over an ALU update.
- R7: `status_out` has carry in bit 0, zero in bit 1, overflow in bit 6 and negative in bit 7. Bits 2 to 5 always read 0.
- R8: `take_jump` is high when the condition picked by `cond_sel` is true. The encodings are: 0 carry clear, 1 carry set, 2 not equal (Z=0), 3 equal (Z=1), 4 plus (N=0), 5 minus (N=1), 6 overflow clear, 7 overflow set.
- R9: `take_jump` is combinational. It follows a change of `cond_sel` in the same cycle, and it reflects new flag values in the cycle right after the edge that wrote them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flag_src | input | 4 | Flag values from the ALU (0=C,1=Z,2=V,3=N) |
| flag_we | input | 4 | Per-flag ALU update enables, same bit order |
| set_carry | input | 1 | Force carry to 1 |
| clr_carry | input | 1 | Force carry to 0 |
| clr_ovf | input | 1 | Force overflow to 0 |
| pull_en | input | 1 | Restore all flags from `pull_byte` |
| pull_byte | input | 8 | Status byte read from the stack |
| cond_sel | input | 3 | Jump condition selector |
| status_out | output | 8 | Packed status byte for pushing |
| take_jump | output | 1 | Selected condition is true |

## Verification
The bench drives the unit with all write sources active at once, checking that pull beats the set/clear strobes and that those beat an ALU update. A reversed ladder would let an ALU carry of 0 override `set_carry`. It checks the case where set and clear carry are both high, which must give 1. It also pulls bytes with only bits 2 to 5 set, so a design that unpacks the wrong bit positions, or lets those padding bits leak into `status_out`, shows a nonzero byte. Each of the eight selector values is tried against both values of its flag, which catches swapped polarity or a mix-up between negative and overflow. A design that registered `take_jump` would lag by one cycle.

// File: rtl/flagcu_pkg.sv
package flagcu_pkg;

    localparam int NFLAG  = 4;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 3;

    // Flag index inside the internal vector
    typedef enum logic [1:0] {
        F_C = 2'd0,
        F_Z = 2'd1,
        F_V = 2'd2,
        F_N = 2'd3
    } flag_idx_e;

    // Bit positions inside the status byte
    localparam int POS_C = 0;
    localparam int POS_Z = 1;
    localparam int POS_V = 6;
    localparam int POS_N = 7;

    function automatic logic [NFLAG-1:0] unpack_status(input logic [BYTE_W-1:0] b);
        return {b[POS_N], b[POS_V], b[POS_Z], b[POS_C]};
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(input logic [NFLAG-1:0] f);
        logic [BYTE_W-1:0] b;
        b        = '0;
        b[POS_C] = f[F_C];
        b[POS_Z] = f[F_Z];
        b[POS_V] = f[F_V];
        b[POS_N] = f[F_N];
        return b;
    endfunction

    // Selector bits [2:1] pick the flag under test
    function automatic flag_idx_e cond_flag(input logic [SEL_W-1:0] sel);
        flag_idx_e idx;
        unique case (sel[2:1])
            2'd0:    idx = F_C;
            2'd1:    idx = F_Z;
            2'd2:    idx = F_N;
            default: idx = F_V;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/flagcu_bit.sv
module flagcu_bit (
    input  logic clk,
    input  logic rst,
    input  logic restore,
    input  logic restore_val,
    input  logic force_one,
    input  logic force_zero,
    input  logic upd,
    input  logic upd_val,
    output logic q
);

    // Priority ladder: reset, restore, force one, force zero, update, hold
    always_ff @(posedge clk) begin
        if (rst)             q <= 1'b0;
        else if (restore)    q <= restore_val;
        else if (force_one)  q <= 1'b1;
        else if (force_zero) q <= 1'b0;
        else if (upd)        q <= upd_val;
    end

    assert_restore_R5: assert property (@(posedge clk) disable iff (rst)
        restore |=> (q == $past(restore_val)));

    assert_force_over_upd_R6: assert property (@(posedge clk) disable iff (rst)
        (!restore && force_one) |=> q);

    assert_upd_R2: assert property (@(posedge clk) disable iff (rst)
        (!restore && !force_one && !force_zero && upd) |=> (q == $past(upd_val)));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!restore && !force_one && !force_zero && !upd) |=> $stable(q));

endmodule

// File: rtl/flagcu_cond.sv
module flagcu_cond
    import flagcu_pkg::*;
(
    input  logic [NFLAG-1:0] flags,
    input  logic [SEL_W-1:0] sel,
    output logic             cond_true
);

    flag_idx_e idx;
    logic      tested;

    always_comb begin
        idx = cond_flag(sel);
        unique case (idx)
            F_C:     tested = flags[F_C];
            F_Z:     tested = flags[F_Z];
            F_N:     tested = flags[F_N];
            default: tested = flags[F_V];
        endcase
        // Selector bit 0 gives the flag value that makes the test true
        cond_true = (tested == sel[0]);
    end

endmodule

// File: rtl/status_cond_unit.sv
module status_cond_unit
    import flagcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NFLAG-1:0]  flag_src,
    input  logic [NFLAG-1:0]  flag_we,
    input  logic              set_carry,
    input  logic              clr_carry,
    input  logic              clr_ovf,
    input  logic              pull_en,
    input  logic [BYTE_W-1:0] pull_byte,
    input  logic [SEL_W-1:0]  cond_sel,
    output logic [BYTE_W-1:0] status_out,
    output logic              take_jump
);

    logic [NFLAG-1:0] flags;
    logic [NFLAG-1:0] pulled;
    logic [NFLAG-1:0] f_one;
    logic [NFLAG-1:0] f_zero;

    assign pulled = unpack_status(pull_byte);

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        if (i == int'(F_C)) begin : g_carry
            assign f_one[i]  = set_carry;
            assign f_zero[i] = clr_carry;
        end else if (i == int'(F_V)) begin : g_ovf
            assign f_one[i]  = 1'b0;
            assign f_zero[i] = clr_ovf;
        end else begin : g_plain
            assign f_one[i]  = 1'b0;
            assign f_zero[i] = 1'b0;
        end

        flagcu_bit i_bit (
            .clk         (clk),
            .rst         (rst),
            .restore     (pull_en),
            .restore_val (pulled[i]),
            .force_one   (f_one[i]),
            .force_zero  (f_zero[i]),
            .upd         (flag_we[i]),
            .upd_val     (flag_src[i]),
            .q           (flags[i])
        );
    end

    assign status_out = pack_status(flags);

    flagcu_cond i_cond (
        .flags     (flags),
        .sel       (cond_sel),
        .cond_true (take_jump)
    );

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (status_out == '0));

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (!pull_en && set_carry) |=> status_out[POS_C]);

    assert_clrv_R4: assert property (@(posedge clk) disable iff (rst)
        (!pull_en && clr_ovf) |=> !status_out[POS_V]);

    assert_pull_R5: assert property (@(posedge clk) disable iff (rst)
        pull_en |=> (status_out[POS_N] == $past(pull_byte[POS_N])
                     && status_out[POS_Z] == $past(pull_byte[POS_Z])));

    assert_pad_zero_R7: assert property (@(posedge clk) disable iff (rst)
        $past(pull_en) |-> (status_out[5:2] == 4'd0));

    assert_eq_cond_R8: assert property (@(posedge clk) disable iff (rst)
        (cond_sel == 3'd3) |-> (take_jump == status_out[POS_Z]));

    assert_vs_cond_R8: assert property (@(posedge clk) disable iff (rst)
        (cond_sel == 3'd7) |-> (take_jump == status_out[POS_V]));

endmodule

// File: tb/test_status_cond_unit.sv
`timescale 1ns/1ps
module test_status_cond_unit;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] flag_src, flag_we;
    logic       set_carry, clr_carry, clr_ovf, pull_en;
    logic [7:0] pull_byte;
    logic [2:0] cond_sel;
    logic [7:0] status_out;
    logic       take_jump;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model flags: bit0 C, bit1 Z, bit2 V, bit3 N
    logic [3:0] m;

    always #10 clk = ~clk;

    status_cond_unit i_status_cond_unit (
        .clk(clk), .rst(rst), .flag_src(flag_src), .flag_we(flag_we),
        .set_carry(set_carry), .clr_carry(clr_carry), .clr_ovf(clr_ovf),
        .pull_en(pull_en), .pull_byte(pull_byte), .cond_sel(cond_sel),
        .status_out(status_out), .take_jump(take_jump)
    );

    function automatic logic [7:0] exp_byte(input logic [3:0] f);
        return {f[3], f[2], 4'b0000, f[1], f[0]};
    endfunction

    function automatic logic exp_cond(input logic [3:0] f, input logic [2:0] s);
        case (s)
            3'd0: return !f[0];
            3'd1: return  f[0];
            3'd2: return !f[1];
            3'd3: return  f[1];
            3'd4: return !f[3];
            3'd5: return  f[3];
            3'd6: return !f[2];
            default: return f[2];
        endcase
    endfunction

    function automatic logic [3:0] next_model(input logic [3:0] f);
        logic [3:0] n;
        if (rst) return 4'b0;
        if (pull_en) return {pull_byte[7], pull_byte[6], pull_byte[1], pull_byte[0]};
        n = f;
        for (int i = 0; i < 4; i++) if (flag_we[i]) n[i] = flag_src[i];
        if (clr_ovf)   n[2] = 1'b0;
        if (clr_carry) n[0] = 1'b0;
        if (set_carry) n[0] = 1'b1;
        return n;
    endfunction

    task automatic check_byte(input string tag);
        checks++;
        if (status_out !== exp_byte(m)) begin
            fails++;
            $display("FAIL %s: status_out actual %h expected %h", tag, status_out, exp_byte(m));
        end
    endtask

    task automatic check_cond(input string tag);
        checks++;
        if (take_jump !== exp_cond(m, cond_sel)) begin
            fails++;
            $display("FAIL %s: take_jump sel %0d actual %b expected %b",
                     tag, cond_sel, take_jump, exp_cond(m, cond_sel));
        end
    endtask

    task automatic idle_inputs();
        flag_src = 0; flag_we = 0; set_carry = 0; clr_carry = 0;
        clr_ovf = 0; pull_en = 0; pull_byte = 0;
    endtask

    // Called at a falling edge with inputs set; returns at the next falling edge
    task automatic step();
        @(posedge clk);
        m = next_model(m);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_pull(input logic [7:0] b);
        pull_en = 1; pull_byte = b;
        step();
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst = 1; m = 4'hF; cond_sel = 0;
        idle_inputs();
        flag_src = 4'hF; flag_we = 4'hF; set_carry = 1;
        @(negedge clk);
        step();
        check_byte("R1 reset");
        rst = 0;

        // R2: per-flag update, others held
        flag_src = 4'b1010; flag_we = 4'b1111; step(); check_byte("R2 full load");
        flag_src = 4'b0101; flag_we = 4'b0010; step(); check_byte("R2 zero only");
        flag_src = 4'b0000; flag_we = 4'b0000; step(); check_byte("R2 hold");

        // R3: set/clear carry, both together
        clr_carry = 1; step(); check_byte("R3 clear carry");
        set_carry = 1; step(); check_byte("R3 set carry");
        set_carry = 1; clr_carry = 1; do_pull(8'h00);
        set_carry = 1; clr_carry = 1; step(); check_byte("R3 set and clear together");

        // R4: clear overflow
        do_pull(8'h40); check_byte("R5 pull V");
        clr_ovf = 1; step(); check_byte("R4 clear overflow");

        // R5 / R7: pull with padding bits
        do_pull(8'hFF); check_byte("R7 pack all ones");
        do_pull(8'h3C); check_byte("R5 padding ignored");
        do_pull(8'h82); check_byte("R5 pull N Z");

        // R6: priority
        do_pull(8'hFF);
        pull_en = 1; pull_byte = 8'h00; set_carry = 1; flag_src = 4'hF; flag_we = 4'hF;
        step(); check_byte("R6 pull over set and alu");
        set_carry = 1; flag_src = 4'h0; flag_we = 4'h1;
        step(); check_byte("R6 set over alu");
        clr_ovf = 1; flag_src = 4'h4; flag_we = 4'h4;
        step(); check_byte("R6 clear over alu");

        // R8 / R9: every selector against both flag values
        for (int p = 0; p < 2; p++) begin
            do_pull(p == 0 ? 8'h00 : 8'hC3);
            for (int s = 0; s < 8; s++) begin
                cond_sel = 3'(s);
                #1;
                check_cond("R8 selector");
            end
        end
        cond_sel = 3'd3;
        flag_src = 4'b0010; flag_we = 4'b0010; do_pull(8'h00);
        flag_src = 4'b0010; flag_we = 4'b0010; step(); #1;
        check_cond("R9 cond after write");

        // Constrained random mix
        for (int k = 0; k < 600; k++) begin
            flag_src  = 4'($urandom);
            flag_we   = 4'($urandom);
            set_carry = ($urandom % 4) == 0;
            clr_carry = ($urandom % 4) == 0;
            clr_ovf   = ($urandom % 4) == 0;
            pull_en   = ($urandom % 8) == 0;
            pull_byte = 8'($urandom);
            rst       = ($urandom % 64) == 0;
            cond_sel  = 3'($urandom);
            #1;
            check_cond("R8 random");
            step();
            rst = 0;
            check_byte("R6 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule